// File: doc/BRIEF.md
# Sinc Decimator with Integrator Stage

This block reduces the rate of an oversampled stream: either a one-bit sigma-delta bitstream or a stream of signed words. A cascaded integrator-comb sinc filter of order 1 to 5 decimates by a filter ratio D. A second integrator stage follows it and adds up I consecutive filter outputs. Each sum is delivered as one wide signed result. Samples enter with a valid strobe, so the block can take input at any rate up to one sample per clock.

While the enable is high the block converts continuously. In normal mode the block refills the whole filter after every result, so every result costs the full fill latency. In fast mode the filter keeps running after the first result, and later results arrive once per D·I samples. With D = 1 the sinc filter is bypassed and only the integrator stage runs. A duration counter, clocked by the system clock, reports how many clock cycles each conversion took.

Top module: `sinc_dec`

## Requirements
- R1: With a one-bit input (IN_W = 1), bit value 1 enters the filter as +1 and bit value 0 enters as -1. Let c be the sample number counted from the start of the conversion, with the first sample numbered 1. A sinc filter output of order N at ratio D is taken at c = m·D + N, for m = 0, 1, 2, ... Its value is the input convolved with N cascaded length-D boxcars, read at sample c-N+1, with samples before the start counted as zero.
- R2: After the enable rises, the first result is due at input sample D·(I-1+N)+N, where D = `fosr_m1`+1, I = `iosr_m1`+1 and N = `order`.
- R3: With `fast_mode` low, every result restarts the conversion from cleared state. Each later result therefore again arrives D·(I-1+N)+N samples after the previous one and depends only on the samples taken since then.
- R4: With `fast_mode` high, each result after the first arrives D·I samples after the previous one. The filter keeps its state between results.
- R5: A result is the modulo-2^ACC_W sum of I consecutive filter outputs. The first N filter outputs after a start are discarded, so a first result sums outputs m = N to N+I-1.
- R6: When `fosr_m1` is 0 the sinc filter is bypassed. A result is then the sum of the last I input samples, a result arrives every I samples in either mode, and `conv_cycles` reads 0 with that result.
- R7: `result_vld` is a one-cycle pulse. It rises in the cycle after the clock edge that accepts the completing sample and is low in every other cycle.
- R8: With each result, `conv_cycles` gives the number of clock edges since the previous result. This count includes any time the enable was low.
- R9: While `enable` is low, no result is produced. Deasserting `enable` clears all integrator, comb and sample-counting state, so the next conversion starts fresh.
- R10: After reset, `result_vld`, `result` and `conv_cycles` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Conversion enable; low clears the filter |
| fast_mode | input | 1 | 1 keeps the filter running between results |
| order | input | 3 | Sinc order 1..MAX_ORD |
| fosr_m1 | input | FOSR_W (10) | Filter ratio minus one; 0 bypasses the filter |
| iosr_m1 | input | IOSR_W (8) | Integrator ratio minus one |
| smp_vld | input | 1 | Input sample strobe |
| smp_data | input | IN_W (1) | Input bit, or a signed word when IN_W > 1 |
| result | output | ACC_W (60) | Signed conversion result |
| result_vld | output | 1 | One-cycle result strobe |
| conv_cycles | output | CNT_W (28) | Duration of the last conversion in clock cycles |

## Verification
A result is due one clock after the edge that accepts sample D·(I-1+N)+N, counted from the enable or, in normal mode, from the last result. In fast mode later results are due every D·I samples, and in bypass every I samples. The bench drives at most one sample per clock, sometimes leaving idle cycles between samples. After every edge it samples `result_vld` at the next falling edge, so the pulse is compared in exactly the cycle it is due and is required low in all others. The bench records the cycle number of each pulse, and the difference between consecutive pulses gives the expected value of `conv_cycles`, including the gaps while the enable is low.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;
   // accumulator width large enough that wrap-around arithmetic stays exact
   function automatic int acc_width(input int in_w, input int max_ord,
                                    input int fosr_w, input int iosr_w);
      return in_w + max_ord * fosr_w + iosr_w + 1;
   endfunction
   function automatic int ord_width(input int max_ord);
      return $clog2(max_ord + 1);
   endfunction
endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
   parameter int W     = 60,
   parameter int N_MAX = 5,
   parameter int OW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [W-1:0]  x,
   input  logic [OW-1:0] ord,
   output logic [W-1:0]  tap
);
   logic [W-1:0] st  [N_MAX];
   logic [W-1:0] nxt [N_MAX];

   for (genvar k = 0; k < N_MAX; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign nxt[k] = st[k] + x;
      end else begin : g_rest
         assign nxt[k] = st[k] + st[k-1];
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < N_MAX; k++) begin
         if (!rst_n || clr) st[k] <= '0;
         else if (step)     st[k] <= nxt[k];
      end
   end

   // the tap is the value the selected stage takes at this edge
   always_comb begin
      tap = '0;
      for (int k = 0; k < N_MAX; k++)
         if (int'(ord) == k + 1) tap = nxt[k];
   end
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
   parameter int W     = 60,
   parameter int N_MAX = 5,
   parameter int OW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [W-1:0]  din,
   input  logic [OW-1:0] ord,
   output logic [W-1:0]  dout
);
   logic [W-1:0] sig [N_MAX+1];
   logic [W-1:0] dly [N_MAX];

   assign sig[0] = din;
   for (genvar k = 0; k < N_MAX; k++) begin : g_cmb
      assign sig[k+1] = (int'(ord) > k) ? sig[k] - dly[k] : sig[k];
   end
   assign dout = sig[N_MAX];

   always_ff @(posedge clk) begin
      for (int k = 0; k < N_MAX; k++) begin
         if (!rst_n || clr) dly[k] <= '0;
         else if (tick)     dly[k] <= sig[k];
      end
   end
endmodule

// File: rtl/sinc_seq.sv
module sinc_seq #(
   parameter int FOSR_W = 10,
   parameter int IOSR_W = 8,
   parameter int OW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic              bypass,
   input  logic [OW-1:0]     ord,
   input  logic [FOSR_W-1:0] fosr_m1,
   input  logic [IOSR_W-1:0] iosr_m1,
   output logic              tick,
   output logic              use_tick,
   output logic              last
);
   logic [OW-1:0]     lead_cnt;
   logic              lead_done;
   logic [FOSR_W-1:0] ph;
   logic [OW-1:0]     disc;
   logic              disc_done;
   logic [IOSR_W-1:0] ic;

   always_comb begin
      if (bypass)          tick = step;
      else if (!lead_done) tick = step && (lead_cnt == ord - OW'(1));
      else                 tick = step && (ph == fosr_m1);
      use_tick = tick && (bypass || disc_done);
      last     = use_tick && (ic == iosr_m1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lead_cnt  <= '0;
         lead_done <= 1'b0;
         ph        <= '0;
         disc      <= '0;
         disc_done <= 1'b0;
         ic        <= '0;
      end else begin
         if (step && !bypass) begin
            if (!lead_done) begin
               if (tick) begin
                  lead_done <= 1'b1;
                  ph        <= '0;
               end else begin
                  lead_cnt <= lead_cnt + OW'(1);
               end
            end else begin
               ph <= tick ? '0 : ph + FOSR_W'(1);
            end
         end
         if (tick && !bypass && !disc_done) begin
            if (disc == ord - OW'(1)) disc_done <= 1'b1;
            else                      disc      <= disc + OW'(1);
         end
         if (use_tick) ic <= last ? '0 : ic + IOSR_W'(1);
      end
   end

   // R1
   lead_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lead_done |-> lead_cnt < ord);
   // R2
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_done |-> ph <= fosr_m1);
   // R5
   integ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ic <= iosr_m1);
endmodule

// File: rtl/sinc_dec.sv
module sinc_dec #(
   parameter int IN_W    = 1,
   parameter int MAX_ORD = 5,
   parameter int FOSR_W  = 10,
   parameter int IOSR_W  = 8,
   parameter int CNT_W   = 28,
   localparam int OW     = sinc_dec_pkg::ord_width(MAX_ORD),
   localparam int ACC_W  = sinc_dec_pkg::acc_width(IN_W, MAX_ORD, FOSR_W, IOSR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fast_mode,
   input  logic [OW-1:0]     order,
   input  logic [FOSR_W-1:0] fosr_m1,
   input  logic [IOSR_W-1:0] iosr_m1,
   input  logic              smp_vld,
   input  logic [IN_W-1:0]   smp_data,
   output logic [ACC_W-1:0]  result,
   output logic              result_vld,
   output logic [CNT_W-1:0]  conv_cycles
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (MAX_ORD < 1 || MAX_ORD > 7) begin : g_bad_ord
      $error("sinc_dec: MAX_ORD must lie in 1..7");
   end
   if (IN_W < 1 || IN_W >= ACC_W) begin : g_bad_in
      $error("sinc_dec: IN_W out of range");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("sinc_dec: CNT_W too small");
   end

   logic [ACC_W-1:0] x, tap, cmb, y, acc;
   logic [OW-1:0]    ord_e;
   logic             bypass, step, clr, tick, use_tick, last;
   logic [CNT_W-1:0] cnt;

   // input mapping: bitstream to +1/-1, or sign-extended word
   if (IN_W == 1) begin : g_serial
      assign x = smp_data[0] ? ACC_W'(1) : {ACC_W{1'b1}};
   end else begin : g_parallel
      assign x = {{(ACC_W-IN_W){smp_data[IN_W-1]}}, smp_data};
   end

   always_comb begin
      if (order == '0)                 ord_e = OW'(1);
      else if (int'(order) > MAX_ORD)  ord_e = OW'(MAX_ORD);
      else                             ord_e = order;
   end

   assign bypass = (fosr_m1 == '0);
   assign step   = enable && smp_vld;
   assign clr    = !enable || (last && !fast_mode);

   sinc_seq #(.FOSR_W(FOSR_W), .IOSR_W(IOSR_W), .OW(OW)) i_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .bypass(bypass),
      .ord(ord_e), .fosr_m1(fosr_m1), .iosr_m1(iosr_m1),
      .tick(tick), .use_tick(use_tick), .last(last));

   sinc_integ #(.W(ACC_W), .N_MAX(MAX_ORD), .OW(OW)) i_integ (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .x(x),
      .ord(ord_e), .tap(tap));

   sinc_comb #(.W(ACC_W), .N_MAX(MAX_ORD), .OW(OW)) i_comb (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick && !bypass),
      .din(tap), .ord(ord_e), .dout(cmb));

   assign y = bypass ? x : cmb;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  acc <= '0;
      else if (use_tick)  acc <= last ? '0 : acc + y;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result     <= '0;
         result_vld <= 1'b0;
      end else begin
         result_vld <= last;
         if (last) result <= acc + y;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt         <= '0;
         conv_cycles <= '0;
      end else if (last) begin
         cnt         <= '0;
         conv_cycles <= bypass ? '0 : ((cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_W'(1));
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R7
   res_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |-> $past(enable && smp_vld));
   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !result_vld);
   // R6
   byp_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result_vld && $past(fosr_m1 == '0)) |-> conv_cycles == '0);
   // R8
   dur_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result_vld && $past(fosr_m1 != '0)) |-> conv_cycles != '0);
endmodule

// File: tb/test_sinc_dec.sv
module test_sinc_dec;
   localparam int IN_W = 1, MAX_ORD = 5, FOSR_W = 10, IOSR_W = 8, CNT_W = 28;
   localparam int OW    = sinc_dec_pkg::ord_width(MAX_ORD);
   localparam int ACC_W = sinc_dec_pkg::acc_width(IN_W, MAX_ORD, FOSR_W, IOSR_W);

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, fast_mode = 1'b0, smp_vld = 1'b0;
   logic [OW-1:0] order = 3'd1;
   logic [FOSR_W-1:0] fosr_m1 = '0;
   logic [IOSR_W-1:0] iosr_m1 = '0;
   logic [IN_W-1:0] smp_data = '0;
   logic [ACC_W-1:0] result;
   logic result_vld;
   logic [CNT_W-1:0] conv_cycles;

   sinc_dec i_sinc_dec (.clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
      .order(order), .fosr_m1(fosr_m1), .iosr_m1(iosr_m1), .smp_vld(smp_vld),
      .smp_data(smp_data), .result(result), .result_vld(result_vld),
      .conv_cycles(conv_cycles));

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [15:0] lf = 16'hACE1;
   bit     sbit [1:2048];
   longint xs   [1:2048];
   bit     ev   [1:2048];
   longint er   [1:2048];
   string  et   [1:2048];
   longint h    [0:63];
   int     hl;
   bit     have_prev = 0;
   longint prev_cyc = 0;

   function automatic bit rnd();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      return lf[0];
   endfunction

   task automatic chk(input bit ok, input string tg, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tg, act, exp, cyc);
      end
   endtask

   task automatic build_h(input int n, input int d);
      longint t [0:63];
      hl = 1;
      for (int i = 0; i < 64; i++) h[i] = 0;
      h[0] = 1;
      repeat (n) begin
         for (int i = 0; i < 64; i++) t[i] = 0;
         for (int i = 0; i < hl; i++)
            for (int j = 0; j < d; j++) t[i+j] += h[i];
         hl += d - 1;
         for (int i = 0; i < 64; i++) h[i] = t[i];
      end
   endtask

   function automatic longint xl(input int s0, input int l);
      return (l >= 1) ? xs[s0 + l - 1] : 0;
   endfunction

   function automatic longint yv(input int s0, input int c, input int n);
      longint s = 0;
      for (int j = 0; j < hl; j++) s += h[j] * xl(s0, c - n + 1 - j);
      return s;
   endfunction

   task automatic step(input bit v, input bit b, input bit e, input longint r,
                       input string vtg, input string rtg, input bit byp);
      longint a;
      smp_vld = v;
      smp_data = b;
      @(posedge clk);
      @(negedge clk);
      smp_vld = 1'b0;
      chk(result_vld === e, vtg, longint'(result_vld), longint'(e));
      if (result_vld) begin
         a = $signed(result);
         if (e) chk(a == r, rtg, a, r);
         if (have_prev)
            chk(longint'(conv_cycles) == (byp ? 0 : cyc - prev_cyc), byp ? "R6" : "R8",
                longint'(conv_cycles), byp ? 0 : cyc - prev_cyc);
         have_prev = 1;
         prev_cyc = cyc;
      end
   endtask

   // pat: 0 random, 1 all ones, 2 all zeros; abort_n > 0 drives that many samples without result
   task automatic run_cfg(input int n, input int d, input int io, input bit fst,
                          input int nres, input int pat, input bit gaps, input int abort_n);
      bit byp;
      int ls, total, ck, s0, kk, c;
      longint r;
      byp = (d == 1);
      enable = 1'b0;
      repeat (3) step(0, 0, 0, 0, "R9", "R9", byp);
      order = OW'(n);
      fosr_m1 = FOSR_W'(d - 1);
      iosr_m1 = IOSR_W'(io - 1);
      fast_mode = fst;
      build_h(n, d);
      ls = byp ? io : d * (io - 1 + n) + n;
      total = 0;
      for (int i = 1; i <= 2048; i++) begin
         ev[i] = 0;
         er[i] = 0;
         et[i] = "R7";
      end
      for (int k = 1; k <= nres; k++) begin
         if (fst) ck = ls + (k - 1) * (byp ? io : d * io);
         else     ck = k * ls;
         total = ck;
      end
      if (abort_n > 0) total = abort_n;
      for (int i = 1; i <= total; i++) begin
         sbit[i] = (pat == 1) ? 1'b1 : (pat == 2) ? 1'b0 : rnd();
         xs[i] = sbit[i] ? 1 : -1;
      end
      if (abort_n == 0) begin
         for (int k = 1; k <= nres; k++) begin
            if (fst) ck = ls + (k - 1) * (byp ? io : d * io);
            else     ck = k * ls;
            r = 0;
            if (byp) begin
               for (int t = ck - io + 1; t <= ck; t++) r += xs[t];
            end else begin
               s0 = fst ? 1 : (k - 1) * ls + 1;
               kk = fst ? k : 1;
               for (int m = n + (kk - 1) * io; m <= n + kk * io - 1; m++) begin
                  c = m * d + n;
                  r += yv(s0, c, n);
               end
            end
            ev[ck] = 1;
            er[ck] = r;
            et[ck] = byp ? "R6" : (k == 1) ? "R2" : (fst ? "R4" : "R3");
         end
      end
      enable = 1'b1;
      for (int i = 1; i <= total; i++) begin
         if (gaps && rnd()) step(0, 0, 0, 0, "R7", "R7", byp);
         step(1, sbit[i], ev[i], er[i],
              ev[i] ? (byp ? "R6" : "R2") : "R7",
              (pat == 0) ? {et[i], " R1 R5"} : et[i], byp);
      end
      enable = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      chk(result_vld === 1'b0, "R10", longint'(result_vld), 0);
      chk(result == '0, "R10", $signed(result), 0);
      chk(conv_cycles == '0, "R10", longint'(conv_cycles), 0);
      // constant inputs: 2 * 4^5 per result, and -(4 * 8^3)
      run_cfg(5, 4, 2, 1, 3, 1, 0, 0);
      run_cfg(3, 8, 4, 0, 2, 2, 1, 0);
      // R9: abort part-way, then a fresh run whose duration spans the gap
      run_cfg(4, 3, 3, 0, 0, 0, 0, 10);
      repeat (7) step(0, 0, 0, 0, "R9", "R9", 0);
      run_cfg(4, 3, 3, 0, 2, 0, 0, 0);
      for (int n = 1; n <= 5; n++)
         for (int di = 0; di < 4; di++)
            for (int io = 1; io <= 3; io++)
               for (int f = 0; f < 2; f++)
                  run_cfg(n, (di == 0) ? 1 : (di == 3) ? 5 : di + 1, io, f[0], 3, 0,
                          ((n + di + io) % 2) == 1, 0);
      // bypass with a larger integrator ratio
      run_cfg(2, 1, 9, 0, 3, 0, 1, 0);
      run_cfg(1, 2, 1, 1, 4, 0, 0, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule